// File: doc/BRIEF.md
# Warp Branch Reconvergence Stack

This block steers the control flow of one 32-lane SIMD warp whose lanes may disagree on branch direction. It holds the warp's program counter and active lane mask, along with a stack of tokens. Each token records a code address, a kind (sync point, divergence, or call) and a lane mask. Because every token carries its kind, forward divergent branches, loop branches and subroutine calls can all share the one stack.

The front end presents one decoded control operation per cycle. Each operation carries its own PC, a target address and the warp's predicate vector. The block then computes the next PC and the next active mask, pushes or pops a token as the operation requires, and raises sticky flags when the stack overflows or underflows. Instruction decode, predicate evaluation and the datapath sit outside the block.

Operations arrive on a valid/ready interface. `op_ready` is held high at all times, so an operation is accepted in any cycle where `op_valid` is high, and the block never applies back-pressure. The result of an accepted operation appears on `pc_out`/`mask_out` one cycle later, with `res_valid` high for that cycle. The result output has no ready signal, so the consumer must take it in that cycle.

Top module: `warp_reconv_stack`

## Requirements
- R1: After reset, `pc_out` equals RESET_PC (default 0), `mask_out` is all ones, both flags are clear and the stack is empty.
- R2: Operation codes are SEQ=0, SYNC=1, BRA=2, JOIN=3, CALL=4, RET=5, and codes 6 and 7 act as SEQ. SEQ gives pc = op_pc + PC_STEP (default 8) with the mask unchanged. `op_ready` is always 1, and `res_valid` rises in the cycle after each accepted operation.
- R3: SYNC pushes a sync token holding op_target and the current mask, then continues at op_pc + PC_STEP.
- R4: BRA with some, but not all, active lanes predicated on pushes a divergence token holding op_pc + PC_STEP and the active lanes whose predicate is off. It then jumps to op_target with only the predicated active lanes left on.
- R5: BRA ignores predicate bits of inactive lanes. If every active lane is predicated on, the warp jumps to op_target. If none is, it continues at op_pc + PC_STEP. In both cases no token is pushed and the mask is unchanged.
- R6: JOIN with a divergence token on top loads both PC and mask from the token and pops it.
- R7: JOIN with a sync token on top restores only the mask from the token, pops it, and continues at op_pc + PC_STEP.
- R8: CALL pushes a call token holding op_pc + PC_STEP and the current mask, then jumps to op_target with the mask unchanged.
- R9: RET with a call token on top loads PC and mask from the token and pops it. RET with any other kind of token on top pops nothing and continues at op_pc + PC_STEP.
- R10: A push while DEPTH (default 16) tokens are held discards the token and sets the sticky `stack_ovf` flag. PC and mask still update as they would otherwise.
- R11: JOIN or RET on an empty stack sets the sticky `stack_unf` flag and continues at op_pc + PC_STEP with the mask unchanged.
- R12: JOIN with a call token on top pops nothing and continues at op_pc + PC_STEP with the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A control operation is offered |
| op_ready | output | 1 | Operation accepted (always 1) |
| op_code | input | 3 | Operation code |
| op_pc | input | 32 | PC of the offered operation |
| op_target | input | 32 | Branch/call target, or reconvergence address for SYNC |
| op_pred | input | 32 | Per-lane branch predicate |
| res_valid | output | 1 | Result of the previous accepted operation is on the outputs |
| pc_out | output | 32 | Next PC of the warp |
| mask_out | output | 32 | Active lane mask |
| stack_ovf | output | 1 | Sticky overflow flag |
| stack_unf | output | 1 | Sticky underflow flag |

## Verification
The branch rule is driven with several predicates:
- a half split, where the lanes genuinely disagree;
- all ones, and all ones under a partial mask, where the predicate bits of inactive lanes must be ignored;
- all zeros.

Together these separate a true divergence from the two uniform outcomes. Nested sync/branch/join regions check that the order in which tokens are restored is correct. CALL/JOIN/RET and SYNC/RET pairs check that the token kind decides whether a pop happens. A run of seventeen SYNC operations followed by seventeen JOINs drives the stack past both of its limits, which shows that the flags are sticky and that a discarded token is never restored. A reference model in the bench predicts PC, mask and flags for every operation.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  parameter int unsigned WARP_LANES = 32;
  parameter int unsigned ADDR_W     = 32;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_SYNC = 3'd1,
    OP_BRA  = 3'd2,
    OP_JOIN = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } ctl_op_e;

  typedef enum logic [1:0] {
    TK_SYNC = 2'd0,
    TK_DIV  = 2'd1,
    TK_CALL = 2'd2
  } tok_kind_e;

  typedef struct packed {
    tok_kind_e               kind;
    logic [ADDR_W-1:0]       addr;
    logic [WARP_LANES-1:0]   lanes;
  } token_t;
endpackage

// File: rtl/wstk_token_stack.sv
module wstk_token_stack
  import wstk_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push_i,
  input  logic   pop_i,
  input  token_t entry_i,
  output token_t top_o,
  output logic   empty_o,
  output logic   full_o,
  output logic   ovf_o,
  output logic   unf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  token_t            slot [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = cnt_q - 1'b1;
  assign top_o   = empty_o ? '0 : slot[top_idx[PTR_W-1:0]];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && !full_o && cnt_q == CNT_W'(g)) slot[g] <= entry_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (push_i) begin
        if (full_o) ovf_o <= 1'b1;
        else        cnt_q <= cnt_q + 1'b1;
      end else if (pop_i) begin
        if (empty_o) unf_o <= 1'b1;
        else         cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o);
  assert_push_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full_o) |=> (top_o == $past(entry_i)));
  assert_full_push_keeps_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> $stable(top_o));
endmodule

// File: rtl/wstk_flow_ctl.sv
module wstk_flow_ctl
  import wstk_pkg::*;
#(
  parameter int unsigned PC_STEP = 8
) (
  input  logic [2:0]            op_i,
  input  logic [ADDR_W-1:0]     op_pc_i,
  input  logic [ADDR_W-1:0]     op_target_i,
  input  logic [WARP_LANES-1:0] op_pred_i,
  input  logic [WARP_LANES-1:0] cur_mask_i,
  input  token_t                top_i,
  input  logic                  empty_i,
  output logic [ADDR_W-1:0]     nxt_pc_o,
  output logic [WARP_LANES-1:0] nxt_mask_o,
  output logic                  push_o,
  output logic                  pop_o,
  output token_t                entry_o
);
  logic [ADDR_W-1:0]     seq_pc;
  logic [WARP_LANES-1:0] taken, stay;

  always_comb begin
    seq_pc     = op_pc_i + ADDR_W'(PC_STEP);
    taken      = op_pred_i & cur_mask_i;
    stay       = cur_mask_i & ~op_pred_i;
    nxt_pc_o   = seq_pc;
    nxt_mask_o = cur_mask_i;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    entry_o    = '0;
    case (op_i)
      OP_SYNC: begin
        push_o        = 1'b1;
        entry_o.kind  = TK_SYNC;
        entry_o.addr  = op_target_i;
        entry_o.lanes = cur_mask_i;
      end
      OP_BRA: begin
        if (taken == cur_mask_i) begin
          nxt_pc_o = op_target_i;
        end else if (taken != '0) begin
          push_o        = 1'b1;
          entry_o.kind  = TK_DIV;
          entry_o.addr  = seq_pc;
          entry_o.lanes = stay;
          nxt_pc_o      = op_target_i;
          nxt_mask_o    = taken;
        end
      end
      OP_JOIN: begin
        if (empty_i) begin
          pop_o = 1'b1;
        end else if (top_i.kind == TK_DIV) begin
          pop_o      = 1'b1;
          nxt_pc_o   = top_i.addr;
          nxt_mask_o = top_i.lanes;
        end else if (top_i.kind == TK_SYNC) begin
          pop_o      = 1'b1;
          nxt_mask_o = top_i.lanes;
        end
      end
      OP_CALL: begin
        push_o        = 1'b1;
        entry_o.kind  = TK_CALL;
        entry_o.addr  = seq_pc;
        entry_o.lanes = cur_mask_i;
        nxt_pc_o      = op_target_i;
      end
      OP_RET: begin
        if (empty_i) begin
          pop_o = 1'b1;
        end else if (top_i.kind == TK_CALL) begin
          pop_o      = 1'b1;
          nxt_pc_o   = top_i.addr;
          nxt_mask_o = top_i.lanes;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
  import wstk_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned PC_STEP  = 8,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [2:0]  op_code,
  input  logic [31:0] op_pc,
  input  logic [31:0] op_target,
  input  logic [31:0] op_pred,
  output logic        res_valid,
  output logic [31:0] pc_out,
  output logic [31:0] mask_out,
  output logic        stack_ovf,
  output logic        stack_unf
);
  logic [ADDR_W-1:0]     pc_q, nxt_pc;
  logic [WARP_LANES-1:0] mask_q, nxt_mask;
  logic                  vld_q;
  logic                  push_req, pop_req;
  token_t                top, entry;
  logic                  empty, full;

  assign op_ready = 1'b1;

  wstk_flow_ctl #(.PC_STEP(PC_STEP)) u_flow (
    .op_i       (op_code),
    .op_pc_i    (op_pc),
    .op_target_i(op_target),
    .op_pred_i  (op_pred),
    .cur_mask_i (mask_q),
    .top_i      (top),
    .empty_i    (empty),
    .nxt_pc_o   (nxt_pc),
    .nxt_mask_o (nxt_mask),
    .push_o     (push_req),
    .pop_o      (pop_req),
    .entry_o    (entry)
  );

  wstk_token_stack #(.DEPTH(DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (op_valid && push_req),
    .pop_i  (op_valid && pop_req),
    .entry_i(entry),
    .top_o  (top),
    .empty_o(empty),
    .full_o (full),
    .ovf_o  (stack_ovf),
    .unf_o  (stack_unf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      mask_q <= '1;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= op_valid;
      if (op_valid) begin
        pc_q   <= nxt_pc;
        mask_q <= nxt_mask;
      end
    end
  end

  assign pc_out    = pc_q;
  assign mask_out  = mask_q;
  assign res_valid = vld_q;

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_mask_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '0);
  assert_bra_narrows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_BRA) |=> ((mask_q & ~$past(mask_q)) == '0));
  assert_div_join_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_JOIN && !empty && top.kind == TK_DIV)
      |=> (pc_q == $past(top.addr) && mask_q == $past(top.lanes)));
  assert_sync_join_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_JOIN && !empty && top.kind == TK_SYNC)
      |=> (mask_q == $past(top.lanes)));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(pc_q) && $stable(mask_q)));
endmodule

// File: tb/warp_reconv_stack_test.sv
module warp_reconv_stack_test;
  localparam int DEPTH = 16;
  localparam int STEP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_pc = '0, op_target = '0, op_pred = '0;
  logic        res_valid;
  logic [31:0] pc_out, mask_out;
  logic        stack_ovf, stack_unf;

  always #4 clk = ~clk;

  warp_reconv_stack #(.DEPTH(DEPTH), .PC_STEP(STEP), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_pc(op_pc), .op_target(op_target), .op_pred(op_pred),
    .res_valid(res_valid), .pc_out(pc_out), .mask_out(mask_out),
    .stack_ovf(stack_ovf), .stack_unf(stack_unf)
  );

  typedef struct {
    logic [31:0] pc;
    logic [31:0] mask;
    logic        ovf;
    logic        unf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_pc, m_mask;
  logic [1:0]  m_kind [DEPTH];
  logic [31:0] m_addr [DEPTH];
  logic [31:0] m_lanes[DEPTH];
  int          m_cnt;
  logic        m_ovf, m_unf;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_push(logic [1:0] k, logic [31:0] a, logic [31:0] l);
    if (m_cnt == DEPTH) m_ovf = 1'b1;
    else begin
      m_kind[m_cnt] = k; m_addr[m_cnt] = a; m_lanes[m_cnt] = l; m_cnt++;
    end
  endtask

  // kinds: 0 sync, 1 div, 2 call
  task automatic send(logic [2:0] code, logic [31:0] pc, logic [31:0] tgt,
                      logic [31:0] pred, string tag);
    logic [31:0] seq, tk;
    exp_t e;
    seq = pc + STEP;
    tk  = pred & m_mask;
    case (code)
      3'd1: begin m_push(2'd0, tgt, m_mask); m_pc = seq; end
      3'd2: begin
        if (tk == m_mask) m_pc = tgt;
        else if (tk == 0) m_pc = seq;
        else begin m_push(2'd1, seq, m_mask & ~pred); m_pc = tgt; m_mask = tk; end
      end
      3'd3: begin
        if (m_cnt == 0) begin m_unf = 1'b1; m_pc = seq; end
        else if (m_kind[m_cnt-1] == 2'd1) begin
          m_pc = m_addr[m_cnt-1]; m_mask = m_lanes[m_cnt-1]; m_cnt--;
        end else if (m_kind[m_cnt-1] == 2'd0) begin
          m_mask = m_lanes[m_cnt-1]; m_cnt--; m_pc = seq;
        end else m_pc = seq;
      end
      3'd4: begin m_push(2'd2, seq, m_mask); m_pc = tgt; end
      3'd5: begin
        if (m_cnt == 0) begin m_unf = 1'b1; m_pc = seq; end
        else if (m_kind[m_cnt-1] == 2'd2) begin
          m_pc = m_addr[m_cnt-1]; m_mask = m_lanes[m_cnt-1]; m_cnt--;
        end else m_pc = seq;
      end
      default: m_pc = seq;
    endcase
    e.pc = m_pc; e.mask = m_mask; e.ovf = m_ovf; e.unf = m_unf; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    checks++;
    if (op_ready !== 1'b1) begin
      errors++;
      $display("FAIL R2 op_ready: actual %b expected 1", op_ready);
    end
    op_valid = 1'b1; op_code = code; op_pc = pc; op_target = tgt; op_pred = pred;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor: compare each result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected result: actual %h expected none", pc_out);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, pc_out, e.pc, "pc");
        check(e.tag, mask_out, e.mask, "mask");
        check(e.tag, {31'd0, stack_ovf}, {31'd0, e.ovf}, "ovf");
        check(e.tag, {31'd0, stack_unf}, {31'd0, e.unf}, "unf");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h0; m_mask = '1; m_cnt = 0; m_ovf = 1'b0; m_unf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", pc_out, 32'h0, "pc");
    check("R1", mask_out, 32'hFFFF_FFFF, "mask");
    check("R1", {30'd0, stack_ovf, stack_unf}, 32'd0, "flags");
    check("R1", {31'd0, res_valid}, 32'd0, "res_valid");

    // R2 sequential and spare codes
    send(3'd0, 32'h100, 32'h0, 32'h0, "R2");
    send(3'd7, 32'h108, 32'h999, 32'h0, "R2");
    // R3 sync, R4 divergent branch, R6 div join, R7 sync join
    send(3'd1, 32'h110, 32'h400, 32'h0, "R3");
    send(3'd2, 32'h118, 32'h200, 32'h0000_FFFF, "R4");
    send(3'd1, 32'h200, 32'h300, 32'h0, "R3");
    send(3'd2, 32'h208, 32'h280, 32'h0000_00F0, "R4");   // nested split
    send(3'd3, 32'h288, 32'h0, 32'h0, "R6");
    send(3'd3, 32'h218, 32'h0, 32'h0, "R7");
    send(3'd3, 32'h228, 32'h0, 32'h0, "R6");
    send(3'd3, 32'h3F8, 32'h0, 32'h0, "R7");
    // R5 uniform branches, inactive predicate bits ignored
    send(3'd2, 32'h400, 32'h500, 32'hFFFF_FFFF, "R5");
    send(3'd2, 32'h500, 32'h600, 32'h0, "R5");
    send(3'd1, 32'h508, 32'h700, 32'h0, "R3");
    send(3'd2, 32'h510, 32'h600, 32'hA5A5_A5A5, "R4");
    send(3'd2, 32'h600, 32'h680, 32'hFFFF_FFFF, "R5");
    send(3'd2, 32'h680, 32'h6C0, 32'h5A5A_5A5A, "R5");
    send(3'd3, 32'h688, 32'h0, 32'h0, "R6");
    send(3'd3, 32'h6F8, 32'h0, 32'h0, "R7");
    // R8 call, R12 join on call, R9 return
    send(3'd4, 32'h800, 32'h900, 32'h0, "R8");
    send(3'd3, 32'h900, 32'h0, 32'h0, "R12");
    send(3'd5, 32'h908, 32'h0, 32'h0, "R9");
    send(3'd1, 32'h810, 32'hA00, 32'h0, "R3");
    send(3'd5, 32'h818, 32'h0, 32'h0, "R9");
    send(3'd3, 32'h820, 32'h0, 32'h0, "R7");
    // call from a diverged region restores the partial mask
    send(3'd1, 32'hB00, 32'hC00, 32'h0, "R3");
    send(3'd2, 32'hB08, 32'hB40, 32'h0F0F_0F0F, "R4");
    send(3'd4, 32'hB40, 32'hD00, 32'h0, "R8");
    send(3'd5, 32'hD00, 32'h0, 32'h0, "R9");
    send(3'd3, 32'hB48, 32'h0, 32'h0, "R6");
    send(3'd3, 32'hBF8, 32'h0, 32'h0, "R7");
    // R10 overflow: DEPTH+1 pushes; R11 underflow after draining
    for (int i = 0; i <= DEPTH; i++)
      send(3'd1, 32'h1000 + 32'(i * STEP), 32'h2000 + 32'(i), 32'h0, "R10");
    for (int i = 0; i <= DEPTH; i++)
      send(3'd3, 32'h3000 + 32'(i * STEP), 32'h0, 32'h0, i == DEPTH ? "R11" : "R10");
    send(3'd5, 32'h4000, 32'h0, 32'h0, "R11");
    send(3'd0, 32'h4100, 32'h0, 32'h0, "R2");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule